// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Port

This block is a full-duplex asynchronous serial port whose frames carry nine data bits. The extra bit can carry parity or act as an address marker when several nodes share one line. A host write of a byte starts a transmit frame. The ninth transmitted bit comes from a separate control input, captured at the moment of the write. The port raises a transmit-done flag as soon as the stop bit begins.

The receiver listens only while its enable input is high. It oversamples the line with a 16x tick and takes each bit near its middle. When address filtering is on, a frame is kept only if its ninth bit is 1. A finished frame never replaces a byte the host has not yet acknowledged. The transmit-done and receive-ready flags stay set until the host pulses the matching clear strobe. An interrupt line reports either flag when interrupts are enabled. Bit-rate generation is outside the block; the port is fed a one-cycle tick at sixteen times the bit rate.

Top module: `nbit_mp_uart`

## Requirements
- R1: `txLine` idles at 1. A write (`hostWrEn` high for one cycle) while idle sends eleven bits, each 16 ticks long: a 0 start bit, then `hostWrData` least significant bit first, then the value `txNinth` had in the write cycle, then a 1 stop bit.
- R2: `txDone` goes to 1 at the start of the stop bit. It is 0 during the ninth bit and stays 1 until `txDoneClr` is pulsed.
- R3: A write that arrives while a frame is being sent is ignored. The current frame is not altered and no further frame follows it.
- R4: While `rxEnable` is 0, no frame is received: `rxReady`, `rxData` and `rxNinth` do not change.
- R5: At the stop-bit sample, the eight data bits go to `rxData`, the ninth bit goes to `rxNinth`, and `rxReady` becomes 1, provided `rxReady` was 0 and the filter allows the frame. The level of the stop bit is not checked.
- R6: A frame that ends while `rxReady` is 1 leaves `rxData`, `rxNinth` and `rxReady` unchanged.
- R7: With `addrFilter` at 1, a frame whose ninth bit is 0 is dropped and changes nothing. With `addrFilter` at 0, the ninth bit's value does not affect acceptance.
- R8: A low pulse on `rxLine` that is high again by the middle of the start bit is a false start. Nothing is received and the receiver is ready for the next frame.
- R9: `irq` equals `intEnable` AND (`txDone` OR `rxReady`).
- R10: After reset: `txLine`=1, and `txDone`, `rxReady`, `rxData`, `rxNinth` and `irq` are all 0.
- R11: `rxReadyClr` clears `rxReady`, and `txDoneClr` clears `txDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| hostWrEn | input | 1 | Write strobe for a transmit byte |
| hostWrData | input | 8 | Byte to transmit |
| txNinth | input | 1 | Ninth bit for the next transmit frame |
| rxEnable | input | 1 | Receiver enable |
| addrFilter | input | 1 | Keep only frames whose ninth bit is 1 |
| intEnable | input | 1 | Interrupt enable |
| txDoneClr | input | 1 | Clear strobe for txDone |
| rxReadyClr | input | 1 | Clear strobe for rxReady |
| rxLine | input | 1 | Serial receive pin |
| txLine | output | 1 | Serial transmit pin |
| rxData | output | 8 | Last accepted received byte |
| rxNinth | output | 1 | Ninth bit of the last accepted frame |
| txDone | output | 1 | Transmit-done flag |
| rxReady | output | 1 | Receive-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `tick16` is a single-cycle pulse, no more often than every other clock. They also assume that `rxLine` holds each bit for a whole bit time, measured in those ticks. The bench produces one tick every four clocks and changes `rxLine` only on falling clock edges, holding each bit for exactly 64 clocks. Its shortened stop bit and its false-start pulse are sized to land clearly before or after the receiver's mid-bit sample.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  // Strobes the sequencer hands to the datapath, one cycle each
  typedef struct packed {
    logic txLoad;    // capture byte and ninth bit into the shifter
    logic txShift;   // advance to the next transmit bit
    logic txStop;    // the stop bit is starting
    logic rxClear;   // a start edge was seen, empty the receive shifter
    logic rxShift;   // take a mid-bit sample into the shifter
    logic rxCommit;  // stop-bit sample reached, try to deliver
  } strobe_t;

  typedef enum logic {TX_IDLE, TX_RUN} txState_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rxState_t;

endpackage

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
  import uart9_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    tick,
  input  logic    hostWrEn,
  input  logic    rxEnable,
  input  logic    rxBit,
  output strobe_t stb,
  output logic    txBusy
);

  localparam int SUB_W    = $clog2(OVS);
  localparam int LAST_BIT = DATA_W + 2;  // index of the stop bit
  localparam int IDX_W    = $clog2(LAST_BIT + 1);
  localparam int RX_BITS  = DATA_W + 1;  // data bits plus ninth bit
  localparam int MID      = OVS / 2 - 1;

  txState_t               txState;
  logic [SUB_W-1:0]       txSub;
  logic [IDX_W-1:0]       txIdx;
  rxState_t               rxState;
  logic [SUB_W-1:0]       rxSub;
  logic [IDX_W-1:0]       rxIdx;
  logic                   txBitEnd;
  logic                   rxBitEnd;

  assign txBitEnd = (txState == TX_RUN) && tick && (txSub == SUB_W'(OVS - 1));
  assign rxBitEnd = (rxState == RX_DATA) && tick && (rxSub == SUB_W'(OVS - 1));
  assign txBusy   = (txState == TX_RUN);

  always_comb begin
    stb = '0;
    stb.txLoad = (txState == TX_IDLE) && hostWrEn;
    if (txBitEnd && (txIdx != IDX_W'(LAST_BIT))) begin
      stb.txShift = 1'b1;
      stb.txStop  = (txIdx == IDX_W'(LAST_BIT - 1));
    end
    stb.rxClear = (rxState == RX_IDLE) && tick && rxEnable && !rxBit;
    if (rxBitEnd) begin
      if (rxIdx == IDX_W'(RX_BITS)) stb.rxCommit = 1'b1;
      else                          stb.rxShift  = 1'b1;
    end
  end

  // Transmit sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState <= TX_IDLE;
      txSub   <= '0;
      txIdx   <= '0;
    end else if (stb.txLoad) begin
      txState <= TX_RUN;
      txSub   <= '0;
      txIdx   <= '0;
    end else if (txState == TX_RUN && tick) begin
      txSub <= (txSub == SUB_W'(OVS - 1)) ? '0 : txSub + 1'b1;
      if (txBitEnd) begin
        if (txIdx == IDX_W'(LAST_BIT)) txState <= TX_IDLE;
        else                           txIdx   <= txIdx + 1'b1;
      end
    end
  end

  // Receive sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxSub   <= '0;
      rxIdx   <= '0;
    end else if (tick) begin
      case (rxState)
        RX_IDLE: if (stb.rxClear) begin
          rxState <= RX_START;
          rxSub   <= '0;
        end
        RX_START: begin
          if (rxSub == SUB_W'(MID)) begin
            rxSub <= '0;
            rxIdx <= '0;
            rxState <= rxBit ? RX_IDLE : RX_DATA;
          end else begin
            rxSub <= rxSub + 1'b1;
          end
        end
        RX_DATA: begin
          rxSub <= (rxSub == SUB_W'(OVS - 1)) ? '0 : rxSub + 1'b1;
          if (rxBitEnd) begin
            if (rxIdx == IDX_W'(RX_BITS)) rxState <= RX_IDLE;
            else                          rxIdx   <= rxIdx + 1'b1;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // R4: a disabled receiver never leaves idle
  a_r4_idle_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_IDLE && !rxEnable) |=> (rxState == RX_IDLE));

endmodule

// File: rtl/uart9_dp.sv
module uart9_dp
  import uart9_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              txNinth,
  input  logic              addrFilter,
  input  logic              txDoneClr,
  input  logic              rxReadyClr,
  input  logic              rxLine,
  output logic              txLine,
  output logic              rxBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              txDone,
  output logic              rxReady
);

  localparam int TX_W = DATA_W + 3;  // start, data, ninth, stop

  logic [TX_W-1:0]        txShReg;
  logic [SYNC_STAGES-1:0] syncReg;
  logic [DATA_W:0]        rxShReg;
  logic                   commitOk;

  // Transmit shifter: bit 0 drives the line, ones fill from the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txShReg <= '1;
    else if (stb.txLoad)  txShReg <= {1'b1, txNinth, hostWrData, 1'b0};
    else if (stb.txShift) txShReg <= {1'b1, txShReg[TX_W-1:1]};
  end
  assign txLine = txShReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          txDone <= 1'b0;
    else if (stb.txStop) txDone <= 1'b1;
    else if (txDoneClr) txDone <= 1'b0;
  end

  // Receive line synchronizer
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncReg <= '1;
        else       syncReg <= rxLine;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncReg <= '1;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rxLine};
    end
  endgenerate
  assign rxBit = syncReg[SYNC_STAGES-1];

  // Receive shifter: newest bit enters at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxShReg <= '0;
    else if (stb.rxClear) rxShReg <= '0;
    else if (stb.rxShift) rxShReg <= {rxBit, rxShReg[DATA_W:1]};
  end

  assign commitOk = stb.rxCommit && !rxReady && (!addrFilter || rxShReg[DATA_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxNinth <= 1'b0;
      rxReady <= 1'b0;
    end else if (commitOk) begin
      rxData  <= rxShReg[DATA_W-1:0];
      rxNinth <= rxShReg[DATA_W];
      rxReady <= 1'b1;
    end else if (rxReadyClr) begin
      rxReady <= 1'b0;
    end
  end

  // R2: transmit-done holds until cleared
  a_r2_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !txDoneClr) |=> txDone);

  // R6: an unread byte is never replaced
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    rxReady |=> ($stable(rxData) && $stable(rxNinth)));

  // R7: with filtering on, only frames with ninth bit 1 are accepted
  a_r7_filter: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxReady) && $past(addrFilter)) |-> rxNinth);

endmodule

// File: rtl/nbit_mp_uart.sv
module nbit_mp_uart
  import uart9_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              txNinth,
  input  logic              rxEnable,
  input  logic              addrFilter,
  input  logic              intEnable,
  input  logic              txDoneClr,
  input  logic              rxReadyClr,
  input  logic              rxLine,
  output logic              txLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth,
  output logic              txDone,
  output logic              rxReady,
  output logic              irq
);

  strobe_t stb;
  logic    txBusy;
  logic    rxBit;

  uart9_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick16),
    .hostWrEn (hostWrEn),
    .rxEnable (rxEnable),
    .rxBit    (rxBit),
    .stb      (stb),
    .txBusy   (txBusy)
  );

  uart9_dp #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostWrData (hostWrData),
    .txNinth    (txNinth),
    .addrFilter (addrFilter),
    .txDoneClr  (txDoneClr),
    .rxReadyClr (rxReadyClr),
    .rxLine     (rxLine),
    .txLine     (txLine),
    .rxBit      (rxBit),
    .rxData     (rxData),
    .rxNinth    (rxNinth),
    .txDone     (txDone),
    .rxReady    (rxReady)
  );

  assign irq = intEnable & (txDone | rxReady);

  // R1: the line rests at mark whenever no frame is in flight
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

  // R9: no request without the enable
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intEnable);

endmodule

// File: tb/tb_nbit_mp_uart.sv
module tb_nbit_mp_uart;

  localparam int BITCLK = 64;  // 16 ticks of 4 clocks each

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       hostWrEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic       txNinth = 1'b0;
  logic       rxEnable = 1'b1;
  logic       addrFilter = 1'b0;
  logic       intEnable = 1'b0;
  logic       txDoneClr = 1'b0;
  logic       rxReadyClr = 1'b0;
  logic       rxLine = 1'b1;
  logic       txLine;
  logic [7:0] rxData;
  logic       rxNinth;
  logic       txDone;
  logic       rxReady;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [1:0] tickCnt = '0;

  nbit_mp_uart dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .txNinth(txNinth), .rxEnable(rxEnable),
    .addrFilter(addrFilter), .intEnable(intEnable), .txDoneClr(txDoneClr),
    .rxReadyClr(rxReadyClr), .rxLine(rxLine), .txLine(txLine),
    .rxData(rxData), .rxNinth(rxNinth), .txDone(txDone),
    .rxReady(rxReady), .irq(irq)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    tickCnt <= tickCnt + 2'd1;
    tick16  <= (tickCnt == 2'd3);
  end

  // {data, ninth bit, filter on, frame expected to be accepted}
  localparam logic [10:0] VEC [0:5] = '{
    {8'hA5, 1'b1, 1'b0, 1'b1},
    {8'h3C, 1'b0, 1'b0, 1'b1},
    {8'h81, 1'b1, 1'b1, 1'b1},
    {8'h7E, 1'b0, 1'b1, 1'b0},
    {8'hFF, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseRxClr();
    @(negedge clk) rxReadyClr = 1'b1;
    @(negedge clk) rxReadyClr = 1'b0;
  endtask

  task automatic pulseTxClr();
    @(negedge clk) txDoneClr = 1'b1;
    @(negedge clk) txDoneClr = 1'b0;
  endtask

  // Drive one frame on rxLine; stopLen clocks of stop level, then idle high
  task automatic sendRx(input logic [7:0] d, input logic ninth,
                        input logic stopVal, input int stopLen);
    @(negedge clk) rxLine = 1'b0;
    waitClk(BITCLK);
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      waitClk(BITCLK);
    end
    rxLine = ninth;
    waitClk(BITCLK);
    rxLine = stopVal;
    waitClk(stopLen);
    rxLine = 1'b1;
    waitClk(BITCLK);
  endtask

  // Write a byte, then sample every bit of the outgoing frame at mid-bit
  task automatic txFrame(input logic [7:0] d, input logic ninth, input bit interfere);
    logic [10:0] got;
    int guard;
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = d; txNinth = ninth;
    @(negedge clk);
    hostWrEn = 1'b0; txNinth = ~ninth;  // later changes must not matter
    guard = 0;
    while (txLine !== 1'b0 && guard < 100) begin
      @(negedge clk); guard++;
    end
    waitClk(BITCLK / 2);
    got[0] = txLine;
    if (interfere) begin
      hostWrEn = 1'b1; hostWrData = ~d;
      @(negedge clk) hostWrEn = 1'b0;
      waitClk(BITCLK - 1);
    end else begin
      waitClk(BITCLK);
    end
    for (int i = 1; i <= 9; i++) begin
      got[i] = txLine;
      if (i == 9) chk("R2 done low during ninth bit", txDone, 1'b0);
      waitClk(BITCLK);
    end
    got[10] = txLine;
    chk("R2 done set at stop bit", txDone, 1'b1);
    chk(interfere ? "R3 frame unchanged by busy write" : "R1 frame bits",
        got, {1'b1, ninth, d, 1'b0});
    waitClk(BITCLK);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] expData;
    logic       expNinth;
    int lows;
    waitClk(5);
    // R10: reset state
    chk("R10 txLine", txLine, 1'b1);
    chk("R10 txDone", txDone, 1'b0);
    chk("R10 rxReady", rxReady, 1'b0);
    chk("R10 rxData", rxData, 8'h00);
    chk("R10 rxNinth", rxNinth, 1'b0);
    chk("R10 irq", irq, 1'b0);
    @(negedge clk) rstN = 1'b1;
    waitClk(8);
    expData = 8'h00; expNinth = 1'b0;

    // Vector table: transmit and receive each entry
    for (int v = 0; v < 6; v++) begin
      logic [7:0] d;
      logic nb, mce, acc;
      {d, nb, mce, acc} = VEC[v];
      txFrame(d, nb, 1'b0);
      pulseTxClr();
      chk("R11 txDone cleared", txDone, 1'b0);
      addrFilter = mce;
      sendRx(d, nb, 1'b1, BITCLK);
      if (acc) begin expData = d; expNinth = nb; end
      chk(mce ? "R7 filter accept flag" : "R5 accept flag", rxReady, acc);
      chk(mce ? "R7 data" : "R5 data", rxData, expData);
      chk(mce ? "R7 ninth" : "R5 ninth", rxNinth, expNinth);
      pulseRxClr();
      chk("R11 rxReady cleared", rxReady, 1'b0);
    end
    addrFilter = 1'b0;

    // R5: stop bit level ignored (short low stop, then idle high)
    sendRx(8'h5A, 1'b0, 1'b0, 48);
    waitClk(2 * BITCLK);
    chk("R5 low stop still accepted", rxReady, 1'b1);
    chk("R5 low stop data", rxData, 8'h5A);
    expData = 8'h5A; expNinth = 1'b0;

    // R9: interrupt follows flags and enable
    intEnable = 1'b1;
    waitClk(1);
    chk("R9 irq from rxReady", irq, 1'b1);
    intEnable = 1'b0;
    waitClk(1);
    chk("R9 irq masked", irq, 1'b0);

    // R6: rxReady still set, next frame discarded
    sendRx(8'hC3, 1'b1, 1'b1, BITCLK);
    chk("R6 data kept", rxData, expData);
    chk("R6 ninth kept", rxNinth, expNinth);
    chk("R6 flag still set", rxReady, 1'b1);
    pulseRxClr();
    intEnable = 1'b1;
    waitClk(1);
    chk("R9 irq with no flags", irq, 1'b0);
    intEnable = 1'b0;

    // R4: receiver disabled
    rxEnable = 1'b0;
    sendRx(8'h99, 1'b1, 1'b1, BITCLK);
    chk("R4 no flag while disabled", rxReady, 1'b0);
    chk("R4 data untouched", rxData, expData);
    rxEnable = 1'b1;

    // R8: false start, then a good frame
    @(negedge clk) rxLine = 1'b0;
    waitClk(16);
    rxLine = 1'b1;
    waitClk(12 * BITCLK);
    chk("R8 glitch ignored", rxReady, 1'b0);
    chk("R8 glitch data untouched", rxData, expData);
    sendRx(8'h6B, 1'b1, 1'b1, BITCLK);
    chk("R8 next frame received", rxData, 8'h6B);
    chk("R8 next frame flag", rxReady, 1'b1);
    pulseRxClr();

    // R3: write while busy ignored, no second frame follows
    txFrame(8'hB2, 1'b1, 1'b1);
    lows = 0;
    for (int i = 0; i < 12 * BITCLK; i++) begin
      @(negedge clk);
      if (txLine === 1'b0) lows++;
    end
    chk("R3 no extra frame", lows, 0);
    intEnable = 1'b1;
    waitClk(1);
    chk("R9 irq from txDone", irq, 1'b1);
    pulseTxClr();
    chk("R11 txDone cleared", txDone, 1'b0);
    chk("R9 irq drops", irq, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule